// File: doc/BRIEF.md
# GPIO Expander Pin Control and Interrupt Core

This block is the per-pin control core of a 16-pin I/O expander, organised as two banks of eight pins. A serial-bus slave in front of it turns bus transactions into single-cycle register read and write strobes on a 4-bit address. The core keeps six writable registers for each bank: direction, output level, read polarity, bus-hold enable, pull direction and interrupt mask. It turns them into per-pin output enables, output levels and pull controls.

Pin inputs pass through a two-flop synchroniser. Reading a bank's input register returns the synchronised levels XORed with that bank's polarity bits. The read also stores the raw synchronised levels as the bank's snapshot. An input pin whose level differs from its snapshot bit, and whose mask bit is clear, drives an active-low open-drain interrupt. The interrupt is modelled as a pull-low enable. It goes away when the host reads that bank's input register, or when the pin returns to its snapshot level.

Address map: address = kind × 2 + bank. Kinds are 0 input (read-only), 1 polarity, 2 bus-hold enable, 3 pull select, 4 direction, 5 output, 6 interrupt mask. Addresses 0x0E and 0x0F are unmapped.

Top module: `gpx_core`

## Requirements
- R1: After reset, the direction and interrupt-mask registers read 0xFF, the bus-hold registers read 0xFF, and polarity, pull and output read 0x00. With no writes, every pin is an input (pin_oe all 0), the interrupt is inactive, hold_en is all 1 and pull_en is all 0.
- R2: Each pin's direction bit (address 0x08 + bank, bit i for pin 8·bank+i; 1 = input) sets pin_oe for that pin to its inverse, independently of all other pins.
- R3: The output register (0x0A + bank) appears on pin_out for the matching pins.
- R4: A read strobe puts the addressed register on reg_rdata in the next cycle, and reg_rdata holds until the next read. An input-register read (0x00 + bank) returns the pin levels XORed with the polarity register (0x02 + bank) for any pin stable for two or more cycles.
- R5: When an input-configured, unmasked pin (mask 0x0C + bank, 1 = masked) differs from its snapshot bit, int_n_oe rises after the second clock edge following the pin change. Masked pins and output-configured pins never raise it.
- R6: A read of a bank's input register sets that bank's snapshot to the current levels and clears that bank's interrupt contribution in the same edge. The other bank's contribution is left unchanged.
- R7: When a pin returns to its snapshot level, its interrupt contribution is withdrawn two edges later.
- R8: hold_en follows the bus-hold register (0x04 + bank). Where hold is 0, pull_en is 1 and pull_up follows the pull register (0x06 + bank, 1 = up). Where hold is 1, pull_en and pull_up are 0.
- R9: Writes to the input addresses 0x00–0x01 and to the unmapped addresses 0x0E–0x0F change nothing. Reads of 0x0E–0x0F return 0x00.
- R10: Every writable register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| pin_in | input | 16 | Raw pin levels (asynchronous) |
| pin_oe | output | 16 | Per-pin output enable |
| pin_out | output | 16 | Per-pin output level |
| hold_en | output | 16 | Per-pin bus-hold enable |
| pull_en | output | 16 | Per-pin pull enable |
| pull_up | output | 16 | Per-pin pull direction, 1 = up |
| int_n_oe | output | 1 | Pull-low enable for the open-drain interrupt |

## Verification
Register writes take effect at the edge that samples the strobe. The pin controls are combinational from the registers, so they are checked one cycle after the write is driven. Read data is registered and is sampled on the falling edge after the edge that took the read strobe. The snapshot update and the interrupt clear from R6 land at that same edge. A pin change reaches the interrupt only after the second rising edge, so the bench waits three cycles after changing pins before it reads or checks the interrupt. The directed latency test checks that the interrupt is still low after the first edge and high after the second. All samples are taken on falling edges, midway between the edges that move state.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  // Register kinds; address = kind * banks + bank
  typedef enum logic [2:0] {
    RK_IN   = 3'd0,
    RK_POL  = 3'd1,
    RK_HOLD = 3'd2,
    RK_PULL = 3'd3,
    RK_CFG  = 3'd4,
    RK_OUT  = 3'd5,
    RK_MASK = 3'd6,
    RK_NONE = 3'd7
  } regkind_e;

  localparam int unsigned KINDS = 7;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
  import gpx_pkg::*;
#(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  regkind_e      wr_kind,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] cfg_q,
  output logic [BW-1:0] out_q,
  output logic [BW-1:0] pol_q,
  output logic [BW-1:0] hold_q,
  output logic [BW-1:0] pull_q,
  output logic [BW-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '1;
      mask_q <= '1;
      hold_q <= '1;
      out_q  <= '0;
      pol_q  <= '0;
      pull_q <= '0;
    end else if (wr_en) begin
      case (wr_kind)
        RK_POL:  pol_q  <= wdata;
        RK_HOLD: hold_q <= wdata;
        RK_PULL: pull_q <= wdata;
        RK_CFG:  cfg_q  <= wdata;
        RK_OUT:  out_q  <= wdata;
        RK_MASK: mask_q <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpx_chg.sv
module gpx_chg #(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_in,
  input  logic [BW-1:0] smp,
  input  logic [BW-1:0] cfg,
  input  logic [BW-1:0] mask,
  output logic          pend
);
  logic [BW-1:0] snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     snap <= '0;
    else if (rd_in) snap <= smp;
  end

  // A difference counts only on input pins that are not masked
  assign pend = |((smp ^ snap) & cfg & ~mask);
endmodule

// File: rtl/gpx_core.sv
module gpx_core
  import gpx_pkg::*;
#(
  parameter int unsigned BANKS  = 2,
  parameter int unsigned BW     = 8,
  parameter int unsigned NPIN   = BANKS * BW,
  parameter int unsigned ADDR_W = $clog2(KINDS * BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BW-1:0]     reg_wdata,
  output logic [BW-1:0]     reg_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   hold_en,
  output logic [NPIN-1:0]   pull_en,
  output logic [NPIN-1:0]   pull_up,
  output logic              int_n_oe
);
  logic [BANKS-1:0][BW-1:0] pin_s, cfg, outr, pol, hold, pull, mask;
  logic [BANKS-1:0]         pend;
  logic [NPIN-1:0]          mask_flat;
  logic [ADDR_W-1:0]        kind_raw, bank_raw;
  regkind_e                 acc_kind;
  logic [BW-1:0]            rd_val;

  always_comb begin
    kind_raw = reg_addr / ADDR_W'(BANKS);
    bank_raw = reg_addr % ADDR_W'(BANKS);
    acc_kind = (kind_raw < ADDR_W'(KINDS)) ? regkind_e'(kind_raw[2:0]) : RK_NONE;
  end

  gpx_sync #(.W(NPIN)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (pin_in),
    .q (pin_s)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (bank_raw == ADDR_W'(b));

    gpx_bank #(.BW(BW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr && sel),
      .wr_kind (acc_kind),
      .wdata   (reg_wdata),
      .cfg_q   (cfg[b]),
      .out_q   (outr[b]),
      .pol_q   (pol[b]),
      .hold_q  (hold[b]),
      .pull_q  (pull[b]),
      .mask_q  (mask[b])
    );

    gpx_chg #(.BW(BW)) u_chg (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_in (reg_rd && sel && (acc_kind == RK_IN)),
      .smp   (pin_s[b]),
      .cfg   (cfg[b]),
      .mask  (mask[b]),
      .pend  (pend[b])
    );
  end

  assign pin_oe    = ~cfg;
  assign pin_out   = outr;
  assign hold_en   = hold;
  assign pull_en   = ~hold;
  assign pull_up   = pull & ~hold;
  assign mask_flat = mask;
  assign int_n_oe  = |pend;

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (bank_raw == ADDR_W'(b)) begin
        case (acc_kind)
          RK_IN:   rd_val = pin_s[b] ^ pol[b];
          RK_POL:  rd_val = pol[b];
          RK_HOLD: rd_val = hold[b];
          RK_PULL: rd_val = pull[b];
          RK_CFG:  rd_val = cfg[b];
          RK_OUT:  rd_val = outr[b];
          RK_MASK: rd_val = mask[b];
          default: rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end
endmodule

// File: rtl/gpx_core_chk.sv
module gpx_core_chk #(
  parameter int unsigned NPIN = 16,
  parameter int unsigned BW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic            reg_rd,
  input logic [BW-1:0]   reg_rdata,
  input logic [NPIN-1:0] pin_oe,
  input logic [NPIN-1:0] hold_en,
  input logic [NPIN-1:0] pull_up,
  input logic [NPIN-1:0] mask_flat,
  input logic            int_n_oe
);
  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_rd) |-> $stable(reg_rdata));

  // R2
  oe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr) |-> $stable(pin_oe));

  // R8
  pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_up & hold_en) == '0);

  // R5
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_flat == '1) |-> !int_n_oe);
endmodule

bind gpx_core gpx_core_chk #(.NPIN(NPIN), .BW(BW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_rdata (reg_rdata),
  .pin_oe    (pin_oe),
  .hold_en   (hold_en),
  .pull_up   (pull_up),
  .mask_flat (mask_flat),
  .int_n_oe  (int_n_oe)
);

// File: tb/tb_gpx_core.sv
`timescale 1ns/1ps
module tb_gpx_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_oe, pin_out, hold_en, pull_en, pull_up;
  logic        int_n_oe;

  int errors = 0, checks = 0;
  logic [7:0] m [16];
  logic [7:0] snap [2];

  always #10 clk = ~clk;

  gpx_core dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .hold_en(hold_en),
    .pull_en(pull_en), .pull_up(pull_up), .int_n_oe(int_n_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input int a);
    if (a < 2) return pin_in[a*8 +: 8] ^ m[2 + a];
    if (a > 13) return 8'h00;
    return m[a];
  endfunction

  function automatic bit exp_int();
    for (int b = 0; b < 2; b++)
      if (|((pin_in[b*8 +: 8] ^ snap[b]) & m[8 + b] & ~m[12 + b])) return 1'b1;
    return 1'b0;
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a >= 2 && a <= 13) m[a] = d;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 4'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
    if (a < 2) snap[a] = pin_in[a*8 +: 8];
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_pins(input string tag);
    chk(pin_oe == ~{m[9], m[8]}, {tag, " R2 pin_oe"}, pin_oe, ~{m[9], m[8]});
    chk(pin_out == {m[11], m[10]}, {tag, " R3 pin_out"}, pin_out, {m[11], m[10]});
    chk(hold_en == {m[5], m[4]}, {tag, " R8 hold_en"}, hold_en, {m[5], m[4]});
    chk(pull_en == ~{m[5], m[4]}, {tag, " R8 pull_en"}, pull_en, ~{m[5], m[4]});
    chk(pull_up == ({m[7], m[6]} & ~{m[5], m[4]}), {tag, " R8 pull_up"}, pull_up,
        {m[7], m[6]} & ~{m[5], m[4]});
  endtask

  task automatic chk_read(input int a, input string tag);
    logic [7:0] e, d;
    e = exp_read(a);
    rd(a, d);
    chk(d == e, tag, d, e);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    void'($urandom(32'd4412));
    for (int i = 0; i < 16; i++) m[i] = 8'h00;
    m[4] = 8'hFF; m[5] = 8'hFF; m[8] = 8'hFF; m[9] = 8'hFF; m[12] = 8'hFF; m[13] = 8'hFF;
    snap[0] = 8'h00; snap[1] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state at the pins and in every register
    chk(pin_oe == 16'h0000, "R1 pin_oe", pin_oe, 0);
    chk(int_n_oe == 1'b0, "R1 int", int_n_oe, 0);
    chk(hold_en == 16'hFFFF && pull_en == 16'h0000, "R1 hold/pull", {hold_en, pull_en}, 32'hFFFF0000);
    for (int a = 0; a < 16; a++) chk_read(a, "R1 reset readback");

    // R2 R3 R8 R10: directed writes
    wr(8, 8'hA5); wr(9, 8'h0F); wr(10, 8'h3C); wr(11, 8'hC3);
    wr(4, 8'hF0); wr(6, 8'hFF); wr(5, 8'h00); wr(7, 8'h55);
    chk_pins("directed");
    for (int a = 2; a < 14; a++) chk_read(a, "R10 readback");

    // R9: writes to input and unmapped addresses are ignored
    wr(8, 8'hFF); wr(9, 8'hFF);
    set_pins(16'h1234);
    wr(0, 8'hFF); wr(1, 8'hFF); wr(14, 8'hAA); wr(15, 8'h55);
    chk_pins("R9");
    chk_read(0, "R9 input after write");
    chk_read(1, "R9 input after write");
    chk_read(14, "R9 unmapped read");
    chk_read(15, "R9 unmapped read");

    // R4: polarity inversion
    wr(2, 8'hFF); wr(3, 8'h0F);
    chk_read(0, "R4 inverted read");
    chk_read(1, "R4 inverted read");
    wr(2, 8'h00); wr(3, 8'h00);

    // R5: two-edge latency of an unmasked change
    wr(12, 8'hFE);
    rd(0, d);
    @(negedge clk);
    pin_in[0] = ~pin_in[0];
    @(negedge clk);
    chk(int_n_oe == 1'b0, "R5 not after one edge", int_n_oe, 0);
    @(negedge clk);
    chk(int_n_oe == 1'b1, "R5 after two edges", int_n_oe, 1);
    // R7: back to snapshot withdraws it two edges later
    pin_in[0] = ~pin_in[0];
    @(negedge clk);
    chk(int_n_oe == 1'b1, "R7 still set after one edge", int_n_oe, 1);
    @(negedge clk);
    chk(int_n_oe == 1'b0, "R7 cleared", int_n_oe, 0);

    // R5: a masked pin does not raise it
    set_pins(pin_in ^ 16'h0002);
    chk(int_n_oe == 1'b0, "R5 masked pin", int_n_oe, 0);
    // R5: an output pin does not raise it
    wr(8, 8'hFE);
    set_pins(pin_in ^ 16'h0001);
    chk(int_n_oe == 1'b0, "R5 output pin", int_n_oe, 0);
    wr(8, 8'hFF);
    chk(int_n_oe == 1'b1, "R5 pin back to input", int_n_oe, 1);

    // R6: per-bank clearing by input reads
    wr(13, 8'h00);
    set_pins(pin_in ^ 16'h0100);
    rd(0, d);
    chk(int_n_oe == 1'b1, "R6 bank1 still pending", int_n_oe, 1);
    rd(1, d);
    chk(int_n_oe == 1'b0, "R6 both banks read", int_n_oe, 0);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op, a;
      op = int'($urandom % 3);
      a  = int'($urandom % 16);
      case (op)
        0: begin
          wr(a, 8'($urandom));
          chk_pins("random");
          chk(int_n_oe == exp_int(), "R5 random after write", int_n_oe, exp_int());
        end
        1: begin
          set_pins(16'($urandom));
          chk(int_n_oe == exp_int(), "R5 random pins", int_n_oe, exp_int());
        end
        default: begin
          chk_read(a, "R4 R10 random read");
          chk(int_n_oe == exp_int(), "R6 random after read", int_n_oe, exp_int());
        end
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule